// File: doc/BRIEF.md
# Byte-wide memory controller register file

This block is the configuration and status register file that sits in front of a memory controller and bus arbiter. It answers a 0x500-byte address window in which every register is a single byte placed on a 16-byte stride. Accesses arrive one per cycle as 1, 2 or 4 bytes on a 32-bit data path. The register byte always travels in the most significant byte lane of the access. On reads, the other lanes return zero. On writes, the other lanes are ignored.

The file holds several kinds of register:
- Fixed identification bytes. The board, bus speed and bus master codes are set by parameters.
- One read/write arbiter configuration byte.
- Timing registers that accept writes but store nothing visible.
- A bank of sixteen-bit bank base registers, 26 by default. Each bank base is reached as two byte registers, with the high byte and the low byte interleaved on consecutive strides.

Read data is registered. It appears on `rd_data` after the clock edge that accepts the read and stays there until the next read.

Top module: `mcr_regfile`

## Requirements
- R1: A read of size N (acc_size = 1, 2 or 4) places the addressed register byte at rd_data[(N-1)*8+7:(N-1)*8] with every other bit zero. rd_data changes only on the clock edge that accepts a read and holds its value through idle cycles and writes.
- R2: A write of size N takes the register byte from acc_wdata[(N-1)*8+7:(N-1)*8] and ignores all other bits.
- R3: Offsets 0x1C0 to 0x4F0 inclusive select bank base storage. The slot is (offset-0x1C0)>>4, and the low four offset bits are ignored. An even slot is the high byte and an odd slot is the low byte of bank slot>>1.
- R4: A write to one byte of a bank base leaves the other byte of that bank base, and every other bank, unchanged.
- R5: Offset 0x00 reads the constant 0x39: machine class 3 in bits [5:4], bit 3 set, machine type 1 in bits [2:0].
- R6: Offset 0x20 reads BOARD_CODE in bits [7:5] and zero elsewhere. Code 4 means a video interface is present and code 2 means a second PCI bridge is present. The default of 4 reads 0x80.
- R7: Offset 0x30 reads SPEED_CODE in bits [6:5] and zero elsewhere. The codes are 0 = 40 MHz, 1 = 33 MHz, 2 = 44 MHz and 3 = 50 MHz. The default of 1 reads 0x20.
- R8: Offset 0xB0 reads the one-hot MASTER_CODE shifted left by 3. The codes are video bridge 0x10, PCI bridge one 0x08, PCI bridge two 0x04, primary CPU 0x02 and secondary CPU 0x01. The default primary CPU reads 0x10.
- R9: Offset 0x90 is a read/write byte that returns the last value written to it.
- R10: Offset 0xE0 always reads 0. Writes to 0x50, 0x60, 0x70 and 0x80 are accepted, and those offsets read 0.
- R11: Any other offset reads 0. This includes offsets with non-zero low bits outside the bank range, offsets from 0x4F1 to 0x4FF, and offsets at or above 0x500. Writes to such offsets, or to read-only registers, change no stored register.
- R12: A synchronous active-high reset clears the arbiter byte, every bank base and rd_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 11 | Byte offset within the window |
| acc_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| acc_wdata | input | 32 | Write data; only the top lane of the access is used |
| rd_data | output | 32 | Registered read data, register byte in the top lane |

## Verification
The same registers are read at all three access sizes. Together with writes whose non-selected lanes are filled with distinct bytes, this separates a correct lane choice from a fixed-lane or full-word mistake.

Bank bases are written through both halves with a background pattern that differs per bank. They are read back at the first and last slots, at a slot with non-zero low offset bits, and just past the range. A swap of the high and low bytes, an off-by-one in the slot, or a bound error therefore gives a wrong value.

Writes to read-only, timing, misaligned and out-of-window offsets are followed by reads of the identification constants, the arbiter byte and the banks. A decode that leaks a write into storage is caught this way.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    localparam int OFF_W     = 11;
    localparam int SIZE_W    = 3;
    localparam int STRIDE_SH = 4;

    localparam logic [7:0] CPU_ID_VAL = 8'h39;

    localparam logic [OFF_W-1:0] OFF_CPU_ID = 11'h000;
    localparam logic [OFF_W-1:0] OFF_BOARD  = 11'h020;
    localparam logic [OFF_W-1:0] OFF_SPEED  = 11'h030;
    localparam logic [OFF_W-1:0] OFF_TIME0  = 11'h050;
    localparam logic [OFF_W-1:0] OFF_TIME1  = 11'h060;
    localparam logic [OFF_W-1:0] OFF_REFR   = 11'h070;
    localparam logic [OFF_W-1:0] OFF_ROMT   = 11'h080;
    localparam logic [OFF_W-1:0] OFF_ARB    = 11'h090;
    localparam logic [OFF_W-1:0] OFF_MASTER = 11'h0B0;
    localparam logic [OFF_W-1:0] OFF_L2     = 11'h0E0;
    localparam logic [OFF_W-1:0] OFF_BANK0  = 11'h1C0;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CPU_ID,
        SEL_BOARD,
        SEL_SPEED,
        SEL_TIMING,
        SEL_ARB,
        SEL_MASTER,
        SEL_L2,
        SEL_BANK
    } reg_sel_e;

endpackage

// File: rtl/mcr_decode.sv
module mcr_decode
    import mcr_pkg::*;
#(
    parameter int NUM_BANKS = 26,
    parameter int BIDX_W    = $clog2(NUM_BANKS)
) (
    input  logic [OFF_W-1:0]  offset,
    output reg_sel_e          sel,
    output logic [BIDX_W-1:0] bank,
    output logic              bank_hi
);

    // last byte register of the bank range: two slots per bank
    localparam int BANK_LAST_I = 'h1C0 + (2 * NUM_BANKS - 1) * (1 << STRIDE_SH);
    localparam logic [OFF_W-1:0] BANK_LAST = OFF_W'(BANK_LAST_I);

    logic [OFF_W-1:0] rel;

    always_comb begin
        rel     = offset - OFF_BANK0;
        sel     = SEL_NONE;
        bank    = '0;
        bank_hi = 1'b0;
        if (offset >= OFF_BANK0 && offset <= BANK_LAST) begin
            sel     = SEL_BANK;
            bank    = BIDX_W'(rel >> (STRIDE_SH + 1));
            bank_hi = ~rel[STRIDE_SH];
        end else begin
            unique case (offset)
                OFF_CPU_ID: sel = SEL_CPU_ID;
                OFF_BOARD:  sel = SEL_BOARD;
                OFF_SPEED:  sel = SEL_SPEED;
                OFF_TIME0,
                OFF_TIME1,
                OFF_REFR,
                OFF_ROMT:   sel = SEL_TIMING;
                OFF_ARB:    sel = SEL_ARB;
                OFF_MASTER: sel = SEL_MASTER;
                OFF_L2:     sel = SEL_L2;
                default:    sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mcr_lane.sv
module mcr_lane
    import mcr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [SIZE_W-1:0] size,
    input  logic [7:0]        rd_byte,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic [7:0]        wr_byte
);

    logic [LANE_W-1:0] lane;
    logic [7:0]        pick [LANES];

    assign lane = LANE_W'(size - SIZE_W'(1));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rd_word[i*8 +: 8] = (lane == LANE_W'(i)) ? rd_byte : 8'h00;
        if (i == 0) begin : g_first
            assign pick[i] = (lane == LANE_W'(i)) ? wdata[i*8 +: 8] : 8'h00;
        end else begin : g_rest
            assign pick[i] = pick[i-1] | ((lane == LANE_W'(i)) ? wdata[i*8 +: 8] : 8'h00);
        end
    end

    assign wr_byte = pick[LANES-1];

endmodule

// File: rtl/mcr_bank_store.sv
module mcr_bank_store #(
    parameter int NUM_BANKS = 26,
    parameter int BANK_W    = 16,
    parameter int BIDX_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BIDX_W-1:0] bank,
    input  logic              hi,
    input  logic [7:0]        wr_byte,
    output logic [7:0]        rd_byte
);

    localparam int HALF = BANK_W / 2;

    logic [BANK_W-1:0] bank_q [NUM_BANKS];

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[k] <= '0;
            end else if (wr_en && bank == BIDX_W'(k)) begin
                if (hi) begin
                    bank_q[k][BANK_W-1:HALF] <= wr_byte;
                end else begin
                    bank_q[k][HALF-1:0] <= wr_byte;
                end
            end
        end

        // R4: a low-byte write keeps the high byte of the same bank
        p_keep_high_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && bank == BIDX_W'(k) && !hi) |=> $stable(bank_q[k][BANK_W-1:HALF]));
        // R4: a high-byte write keeps the low byte of the same bank
        p_keep_low_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && bank == BIDX_W'(k) && hi) |=> $stable(bank_q[k][HALF-1:0]));
        // R4: writes aimed at another bank leave this one untouched
        p_other_bank_r4: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && bank == BIDX_W'(k)) |=> $stable(bank_q[k]));
    end

    always_comb begin
        rd_byte = 8'h00;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (bank == BIDX_W'(k)) begin
                rd_byte = hi ? bank_q[k][BANK_W-1:HALF] : bank_q[k][HALF-1:0];
            end
        end
    end

endmodule

// File: rtl/mcr_regfile.sv
module mcr_regfile
    import mcr_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          NUM_BANKS   = 26,
    parameter logic [2:0]  BOARD_CODE  = 3'd4,
    parameter logic [1:0]  SPEED_CODE  = 2'd1,
    parameter logic [4:0]  MASTER_CODE = 5'h02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFF_W-1:0]  acc_offset,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data
);

    localparam int BIDX_W = $clog2(NUM_BANKS);

    reg_sel_e          sel;
    logic [BIDX_W-1:0] bank_idx;
    logic              bank_hi;
    logic [7:0]        wr_byte;
    logic [7:0]        bank_rd;
    logic [7:0]        reg_byte;
    logic [DATA_W-1:0] rd_word;
    logic [7:0]        arb_q;
    logic              rd_go;
    logic              wr_go;

    assign rd_go = acc_valid && !acc_write;
    assign wr_go = acc_valid && acc_write;

    mcr_decode #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_decode (
        .offset  (acc_offset),
        .sel     (sel),
        .bank    (bank_idx),
        .bank_hi (bank_hi)
    );

    mcr_lane #(.DATA_W(DATA_W)) u_lane (
        .size    (acc_size),
        .rd_byte (reg_byte),
        .wdata   (acc_wdata),
        .rd_word (rd_word),
        .wr_byte (wr_byte)
    );

    mcr_bank_store #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_banks (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go && sel == SEL_BANK),
        .bank    (bank_idx),
        .hi      (bank_hi),
        .wr_byte (wr_byte),
        .rd_byte (bank_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arb_q <= 8'h00;
        end else if (wr_go && sel == SEL_ARB) begin
            arb_q <= wr_byte;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CPU_ID: reg_byte = CPU_ID_VAL;
            SEL_BOARD:  reg_byte = {BOARD_CODE, 5'b0};
            SEL_SPEED:  reg_byte = {1'b0, SPEED_CODE, 5'b0};
            SEL_MASTER: reg_byte = {MASTER_CODE, 3'b0};
            SEL_ARB:    reg_byte = arb_q;
            SEL_BANK:   reg_byte = bank_rd;
            default:    reg_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_go) begin
            rd_data <= rd_word;
        end
    end

    // R1: a one-byte read leaves the upper lanes zero
    p_low_lane_only_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_go && acc_size == SIZE_W'(1)) |=> rd_data[DATA_W-1:8] == '0);
    // R1: read data holds when no read is accepted
    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(rd_data));
    // R5: identification constant at offset 0
    p_cpu_id_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_go && acc_offset == OFF_CPU_ID && acc_size == SIZE_W'(1))
            |=> rd_data == DATA_W'(8'h39));
    // R9: arbiter byte changes only on a write to its offset
    p_arb_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_go && acc_offset == OFF_ARB) |=> $stable(arb_q));
    // R10: cache configuration reads zero at any size
    p_l2_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_go && acc_offset == OFF_L2) |=> rd_data == '0);
    // R11: out-of-window reads return zero
    p_outside_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_go && acc_offset >= OFF_W'('h500)) |=> rd_data == '0);

endmodule

// File: tb/mcr_regfile_bench.sv
module mcr_regfile_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 26;

    typedef struct packed {
        logic        wr;
        logic [10:0] off;
        logic [2:0]  sz;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 11'h000, 3'd1, 32'h0,         32'h0000_0039, 8'd5},  // R5
        '{1'b0, 11'h000, 3'd4, 32'h0,         32'h3900_0000, 8'd1},  // R1 size 4
        '{1'b0, 11'h000, 3'd2, 32'h0,         32'h0000_3900, 8'd1},  // R1 size 2
        '{1'b0, 11'h020, 3'd1, 32'h0,         32'h0000_0080, 8'd6},  // R6
        '{1'b0, 11'h030, 3'd1, 32'h0,         32'h0000_0020, 8'd7},  // R7
        '{1'b0, 11'h0B0, 3'd4, 32'h0,         32'h1000_0000, 8'd8},  // R8
        '{1'b0, 11'h0E0, 3'd1, 32'h0,         32'h0000_0000, 8'd10}, // R10
        '{1'b0, 11'h090, 3'd1, 32'h0,         32'h0000_0000, 8'd12}, // R12 reset value
        '{1'b1, 11'h090, 3'd4, 32'hA512_3456, 32'h0,         8'd2},  // R2 top lane
        '{1'b0, 11'h090, 3'd1, 32'h0,         32'h0000_00A5, 8'd9},  // R9
        '{1'b1, 11'h090, 3'd2, 32'h00FF_3CAA, 32'h0,         8'd2},  // R2 lane 1
        '{1'b0, 11'h090, 3'd2, 32'h0,         32'h0000_3C00, 8'd9},  // R9
        '{1'b1, 11'h050, 3'd1, 32'h0000_0077, 32'h0,         8'd10}, // R10 timing write
        '{1'b0, 11'h050, 3'd1, 32'h0,         32'h0000_0000, 8'd10}, // R10
        '{1'b1, 11'h000, 3'd1, 32'h0000_0012, 32'h0,         8'd11}, // R11 read-only
        '{1'b0, 11'h000, 3'd1, 32'h0,         32'h0000_0039, 8'd11}, // R11
        '{1'b1, 11'h1C0, 3'd1, 32'h0000_00AB, 32'h0,         8'd3},  // R3 bank 0 high
        '{1'b1, 11'h1D0, 3'd1, 32'h0000_00CD, 32'h0,         8'd3},  // R3 bank 0 low
        '{1'b0, 11'h1C0, 3'd1, 32'h0,         32'h0000_00AB, 8'd3},  // R3
        '{1'b0, 11'h1D0, 3'd4, 32'h0,         32'hCD00_0000, 8'd3},  // R3
        '{1'b1, 11'h1D0, 3'd1, 32'h0000_0011, 32'h0,         8'd4},  // R4
        '{1'b0, 11'h1C0, 3'd1, 32'h0,         32'h0000_00AB, 8'd4},  // R4 high kept
        '{1'b0, 11'h1D0, 3'd1, 32'h0,         32'h0000_0011, 8'd4},  // R4
        '{1'b1, 11'h4F0, 3'd1, 32'h0000_005A, 32'h0,         8'd3},  // R3 last slot
        '{1'b0, 11'h4F0, 3'd1, 32'h0,         32'h0000_005A, 8'd3},  // R3
        '{1'b0, 11'h4E0, 3'd1, 32'h0,         32'h0000_0000, 8'd4},  // R4 bank 25 high
        '{1'b1, 11'h4F8, 3'd1, 32'h0000_0066, 32'h0,         8'd11}, // R11 past range
        '{1'b0, 11'h4F0, 3'd1, 32'h0,         32'h0000_005A, 8'd11}, // R11
        '{1'b1, 11'h1C5, 3'd1, 32'h0000_009E, 32'h0,         8'd3},  // R3 low bits ignored
        '{1'b0, 11'h1C0, 3'd1, 32'h0,         32'h0000_009E, 8'd3},  // R3
        '{1'b1, 11'h091, 3'd1, 32'h0000_0000, 32'h0,         8'd11}, // R11 misaligned
        '{1'b0, 11'h090, 3'd2, 32'h0,         32'h0000_3C00, 8'd11}, // R11
        '{1'b1, 11'h500, 3'd1, 32'h0000_0042, 32'h0,         8'd11}, // R11 outside
        '{1'b0, 11'h500, 3'd1, 32'h0,         32'h0000_0000, 8'd11}, // R11
        '{1'b0, 11'h010, 3'd1, 32'h0,         32'h0000_0000, 8'd11}, // R11 unlisted
        '{1'b0, 11'h4F1, 3'd1, 32'h0,         32'h0000_0000, 8'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [10:0] acc_offset = '0;
    logic [2:0]  acc_size = 3'd1;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcr_regfile u_mcr_regfile (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_offset (acc_offset),
        .acc_size   (acc_size),
        .acc_wdata  (acc_wdata),
        .rd_data    (rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [10:0] off,
                          input logic [2:0] sz, input logic [31:0] wd);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_offset = off;
        acc_size   = sz;
        acc_wdata  = wd;
        @(negedge clk);
        acc_valid  = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  hi_m [NB];
        logic [7:0]  lo_m [NB];
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 rd_data after reset", rd_data, 32'h0);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            access(TBL[i].wr, TBL[i].off, TBL[i].sz, TBL[i].wd);
            if (!TBL[i].wr) begin
                check($sformatf("R%0d vector %0d", TBL[i].req, i), rd_data, TBL[i].exp);
            end
        end

        // R1: rd_data holds through idle cycles and writes
        access(1'b0, 11'h020, 3'd2, 32'h0);
        held = rd_data;
        check("R6 board code at size 2", held, 32'h0000_8000);
        repeat (3) @(negedge clk);
        access(1'b1, 11'h090, 3'd1, 32'h0000_0001);
        check("R1 hold across idle and write", rd_data, held);

        // R3/R4: fill every bank through both halves, then read back
        for (int k = 0; k < NB; k++) begin
            hi_m[k] = 8'(k * 7 + 3);
            lo_m[k] = 8'hF0 ^ 8'(k);
            if (k % 2 == 0) begin
                access(1'b1, 11'(11'h1C0 + k * 32), 3'd2, {16'hEEEE, hi_m[k], 8'h55});
            end else begin
                access(1'b1, 11'(11'h1C0 + k * 32), 3'd1, {24'hFFFFFF, hi_m[k]});
            end
            access(1'b1, 11'(11'h1D0 + k * 32), 3'd4, {lo_m[k], 24'h0123AB});
        end
        for (int k = 0; k < NB; k++) begin
            access(1'b0, 11'(11'h1C0 + k * 32), 3'd4, 32'h0);
            check($sformatf("R3 bank %0d high", k), rd_data, {hi_m[k], 24'h0});
            access(1'b0, 11'(11'h1D0 + k * 32), 3'd1, 32'h0);
            check($sformatf("R4 bank %0d low", k), rd_data, {24'h0, lo_m[k]});
        end

        // R12: reset mid-run clears storage
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R12 rd_data cleared", rd_data, 32'h0);
        access(1'b0, 11'h090, 3'd1, 32'h0);
        check("R12 arbiter cleared", rd_data, 32'h0);
        access(1'b0, 11'h1C0, 3'd1, 32'h0);
        check("R12 bank 0 high cleared", rd_data, 32'h0);
        access(1'b0, 11'h4F0, 3'd1, 32'h0);
        check("R12 bank 25 low cleared", rd_data, 32'h0);
        access(1'b0, 11'h030, 3'd4, 32'h0);
        check("R7 speed at size 4", rd_data, 32'h2000_0000);

        finish_run();
    end

endmodule